// File: doc/BRIEF.md
# Parallel 8080-Style Panel Write Engine

This block drives a command-mode LCD panel over a parallel 8080-style write bus. It has an active-low chip select, an active-low write strobe and a data bus. Software sets up the engine through a configuration word. The word holds four phase lengths: chip-select setup, strobe setup, strobe active and strobe hold. It also holds an interface enable. A frame is sent only when a trigger command is written. The engine then takes `frame_w_i * frame_h_i` pixel words from a valid/ready stream and sends each word as one write cycle. When the last cycle of the frame is done, it gives a one-cycle done pulse and sets a sticky interrupt flag.

A trigger that arrives while a frame is in flight is dropped, because a repeated trigger can reset the panel. The busy state always ends when the frame completes. This holds even when the interrupt is masked, so the engine can never stay stuck busy. The phase lengths and the frame size are captured when the trigger is accepted. Changing the configuration during a frame therefore cannot corrupt the bus timing.

Top module: `i80_wr_engine`

## Requirements
- R1: After reset, `cs_n_o` and `wr_n_o` are high, and `busy_o`, `done_o`, `irq_o` and `pix_ready_o` are low.
- R2: Configuration word fields:
  - bits 19:16 hold the chip-select setup count;
  - bits 15:12 hold the strobe setup count;
  - bits 11:8 hold the strobe active count;
  - bits 7:4 hold the strobe hold count;
  - bit 0 is the interface enable.

  For each word, `cs_n_o` is low for setup+strobe-setup cycles before `wr_n_o` falls. `wr_n_o` then stays low for the active count. `cs_n_o` stays low for the hold count of cycles after `wr_n_o` rises.
- R3: A strobe active field of 0 gives a strobe of 1 cycle. A setup or hold field of 0 gives 0 cycles.
- R4: A frame starts only on a cycle with `trig_we_i` high, `trig_ctrl_i[0]` (mode select) high, `trig_ctrl_i[1]` (trigger command) high and enable bit 0 set. Any other trigger write has no effect.
- R5: A trigger write accepted while `busy_o` is high is dropped. It starts no further frame afterwards.
- R6: A frame sends exactly `frame_w_i*frame_h_i` words, in arrival order. `db_o` holds each word while `wr_n_o` is low. `pix_ready_o` is high only while busy with no write cycle in progress.
- R7: `done_o` is high for one cycle: the first cycle after the last chip-select-low cycle of the frame. `busy_o` falls in that same cycle, whether or not the interrupt is enabled.
- R8: When a frame completes with `irq_en_i` high, `irq_o` is set and holds. `irq_clr_i` clears it on the next edge. A set in the same cycle wins over a clear. With `irq_en_i` low, `irq_o` is not set.
- R9: The phase counts and the frame size are sampled when the trigger is accepted. Changes to them during the frame have no effect on that frame.
- R10: A trigger with a frame size of zero words produces `done_o` in the next cycle, with no bus cycle and without `busy_o` rising.
- R11: Between two words, `cs_n_o` returns high for at least one cycle, the cycle in which the next word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 4+4*PH_W | Phase counts and enable bit |
| trig_we_i | input | 1 | Trigger control write pulse |
| trig_ctrl_i | input | 2 | Bit 0 mode select, bit 1 trigger command |
| frame_w_i | input | DIM_W | Frame width in words |
| frame_h_i | input | DIM_W | Frame height in lines |
| irq_en_i | input | 1 | Frame-done interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| pix_valid_i | input | 1 | Pixel word valid |
| pix_data_i | input | DATA_W | Pixel word |
| pix_ready_o | output | 1 | Pixel word accepted when high with valid |
| cs_n_o | output | 1 | Panel chip select, active low |
| wr_n_o | output | 1 | Panel write strobe, active low |
| db_o | output | DATA_W | Panel data bus |
| busy_o | output | 1 | Triggered frame in flight |
| done_o | output | 1 | Frame-done pulse |
| irq_o | output | 1 | Sticky frame-done interrupt flag |

## Verification
The bench builds the block with its defaults: 16-bit data, 8-bit frame dimensions and 4-bit phase fields. These widths let every phase count from 0 to 15 be drawn at random, including the zero-setup, zero-hold and zero-active corners. They also keep frames to a handful of words, so mid-frame retriggers, configuration changes, zero-sized frames and back-pressure gaps in the pixel stream all fit in a short run.

// File: rtl/i80_pkg.sv
package i80_pkg;
  typedef enum logic [2:0] {
    PH_WAIT = 3'd0,
    PH_CSS  = 3'd1,
    PH_WRS  = 3'd2,
    PH_ACT  = 3'd3,
    PH_HLD  = 3'd4
  } phase_e;
endpackage

// File: rtl/i80_cfg_snap.sv
module i80_cfg_snap #(
  parameter int PH_W   = 4,
  parameter int DIM_W  = 8,
  localparam int CFG_W = 4 + 4*PH_W,
  localparam int WCNT_W = 2*DIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [PH_W-1:0]   css_o,
  output logic [PH_W-1:0]   wrs_o,
  output logic [PH_W-1:0]   act_o,
  output logic [PH_W-1:0]   hld_o
);
  localparam logic [PH_W-1:0] ONE = 1;

  // field 0 = hold, 1 = active, 2 = strobe setup, 3 = cs setup
  logic [PH_W-1:0] fld [4];
  for (genvar g = 0; g < 4; g++) begin : g_fld
    assign fld[g] = cfg_i[4 + g*PH_W +: PH_W];
  end

  logic cfg_unused;
  assign cfg_unused = ^cfg_i[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      css_o <= '0;
      wrs_o <= '0;
      act_o <= ONE;
      hld_o <= '0;
    end else if (load_i) begin
      css_o <= fld[3];
      wrs_o <= fld[2];
      act_o <= (fld[1] == '0) ? ONE : fld[1];
      hld_o <= fld[0];
    end
  end
endmodule

// File: rtl/i80_phase_fsm.sv
module i80_phase_fsm
  import i80_pkg::*;
#(
  parameter int PH_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PH_W-1:0]   css_i,
  input  logic [PH_W-1:0]   wrs_i,
  input  logic [PH_W-1:0]   act_i,
  input  logic [PH_W-1:0]   hld_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              pix_ready_o,
  output logic              cs_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] db_o,
  output logic              word_end_o
);
  localparam logic [PH_W-1:0] ONE = 1;

  phase_e          ph_q;
  logic [PH_W-1:0] cnt_q;
  logic [DATA_W-1:0] db_q;

  assign pix_ready_o = (ph_q == PH_WAIT) && run_i;
  assign cs_n_o      = (ph_q == PH_WAIT);
  assign wr_n_o      = (ph_q != PH_ACT);
  assign db_o        = db_q;
  assign word_end_o  = (cnt_q == '0) &&
                       (((ph_q == PH_ACT) && (hld_i == '0)) || (ph_q == PH_HLD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_WAIT;
      cnt_q <= '0;
      db_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_WAIT: if (pix_valid_i && pix_ready_o) begin
          db_q <= pix_data_i;
          if (css_i != '0) begin
            ph_q <= PH_CSS; cnt_q <= css_i - ONE;
          end else if (wrs_i != '0) begin
            ph_q <= PH_WRS; cnt_q <= wrs_i - ONE;
          end else begin
            ph_q <= PH_ACT; cnt_q <= act_i - ONE;
          end
        end
        PH_CSS: if (cnt_q != '0) cnt_q <= cnt_q - ONE;
          else if (wrs_i != '0) begin
            ph_q <= PH_WRS; cnt_q <= wrs_i - ONE;
          end else begin
            ph_q <= PH_ACT; cnt_q <= act_i - ONE;
          end
        PH_WRS: if (cnt_q != '0) cnt_q <= cnt_q - ONE;
          else begin
            ph_q <= PH_ACT; cnt_q <= act_i - ONE;
          end
        PH_ACT: if (cnt_q != '0) cnt_q <= cnt_q - ONE;
          else if (hld_i != '0) begin
            ph_q <= PH_HLD; cnt_q <= hld_i - ONE;
          end else ph_q <= PH_WAIT;
        PH_HLD: if (cnt_q != '0) cnt_q <= cnt_q - ONE;
          else ph_q <= PH_WAIT;
        default: ph_q <= PH_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/i80_frame_ctrl.sv
module i80_frame_ctrl #(
  parameter int WCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_we_i,
  input  logic [1:0]        trig_ctrl_i,
  input  logic              en_i,
  input  logic [WCNT_W-1:0] words_i,
  input  logic              word_end_i,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam logic [WCNT_W-1:0] ONE = 1;

  logic [WCNT_W-1:0] rem_q;
  logic busy_q, done_q, irq_q;
  logic start, empty_start, last_end, done_set;

  // a write while busy is dropped, not queued
  assign start       = trig_we_i && (&trig_ctrl_i) && en_i && !busy_q;
  assign empty_start = start && (words_i == '0);
  assign last_end    = busy_q && word_end_i && (rem_q == ONE);
  assign done_set    = empty_start || last_end;
  assign load_o      = start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_set;
      if (start && !empty_start) begin
        busy_q <= 1'b1;
        rem_q  <= words_i;
      end else if (busy_q && word_end_i) begin
        rem_q <= rem_q - ONE;
        if (last_end) busy_q <= 1'b0;
      end
      if (done_set && irq_en_i) irq_q <= 1'b1;
      else if (irq_clr_i)       irq_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/i80_wr_engine.sv
module i80_wr_engine #(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 8,
  parameter int PH_W   = 4,
  localparam int CFG_W  = 4 + 4*PH_W,
  localparam int WCNT_W = 2*DIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              trig_we_i,
  input  logic [1:0]        trig_ctrl_i,
  input  logic [DIM_W-1:0]  frame_w_i,
  input  logic [DIM_W-1:0]  frame_h_i,
  input  logic              irq_en_i,
  input  logic              irq_clr_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              pix_ready_o,
  output logic              cs_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] db_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  logic [WCNT_W-1:0] words_now;
  logic [PH_W-1:0]   css, wrs, act, hld;
  logic              load, word_end;

  assign words_now = WCNT_W'(frame_w_i) * WCNT_W'(frame_h_i);

  i80_cfg_snap #(.PH_W(PH_W), .DIM_W(DIM_W)) u_snap (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load), .cfg_i (cfg_i),
    .css_o (css), .wrs_o (wrs), .act_o (act), .hld_o (hld)
  );

  i80_frame_ctrl #(.WCNT_W(WCNT_W)) u_ctrl (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_we_i (trig_we_i),
    .trig_ctrl_i (trig_ctrl_i), .en_i (cfg_i[0]), .words_i (words_now),
    .word_end_i (word_end), .irq_en_i (irq_en_i), .irq_clr_i (irq_clr_i),
    .load_o (load), .busy_o (busy_o), .done_o (done_o), .irq_o (irq_o)
  );

  i80_phase_fsm #(.PH_W(PH_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (busy_o),
    .css_i (css), .wrs_i (wrs), .act_i (act), .hld_i (hld),
    .pix_valid_i (pix_valid_i), .pix_data_i (pix_data_i),
    .pix_ready_o (pix_ready_o), .cs_n_o (cs_n_o), .wr_n_o (wr_n_o),
    .db_o (db_o), .word_end_o (word_end)
  );
endmodule

// File: rtl/i80_wr_engine_chk.sv
module i80_wr_engine_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_we_i,
  input logic              irq_clr_i,
  input logic              pix_ready_o,
  input logic              cs_n_o,
  input logic              wr_n_o,
  input logic [DATA_W-1:0] db_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              irq_o
);
  a_r2_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> !cs_n_o);

  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> (cs_n_o && busy_o));

  a_r6_db_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o && !$past(wr_n_o)) |-> $stable(db_o));

  a_r7_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> done_o);

  a_r8_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_clr_i && !busy_o && !trig_we_i) |=> !irq_o);

  a_r11_accept_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $past(pix_ready_o));
endmodule

bind i80_wr_engine i80_wr_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .trig_we_i (trig_we_i),
  .irq_clr_i (irq_clr_i), .pix_ready_o (pix_ready_o), .cs_n_o (cs_n_o),
  .wr_n_o (wr_n_o), .db_o (db_o), .busy_o (busy_o), .done_o (done_o),
  .irq_o (irq_o)
);

// File: tb/i80_wr_engine_bench.sv
module i80_wr_engine_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] cfg = '0;
  logic        trig_we = 1'b0;
  logic [1:0]  trig_ctrl = 2'b00;
  logic [7:0]  fw = '0, fh = '0;
  logic        irq_en = 1'b0, irq_clr = 1'b0;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_data = '0;
  logic        pix_ready, cs_n, wr_n, busy, done, irq;
  logic [15:0] db;

  always #4 clk = ~clk;

  i80_wr_engine u_i80_wr_engine (
    .clk_i (clk), .rst_ni (rst_ni), .cfg_i (cfg), .trig_we_i (trig_we),
    .trig_ctrl_i (trig_ctrl), .frame_w_i (fw), .frame_h_i (fh),
    .irq_en_i (irq_en), .irq_clr_i (irq_clr), .pix_valid_i (pix_valid),
    .pix_data_i (pix_data), .pix_ready_o (pix_ready), .cs_n_o (cs_n),
    .wr_n_o (wr_n), .db_o (db), .busy_o (busy), .done_o (done), .irq_o (irq)
  );

  int checks = 0, failures = 0;
  int exp_css, exp_wrs, exp_act, exp_hld, exp_words;
  int words_seen = 0, done_cnt = 0, acc_cnt = 0;
  int cs_len = 0, wr_len = 0, pre = 0, post = 0;
  logic [15:0] db_seen = '0;
  logic [15:0] acc_q [0:255];
  bit drv_on = 1'b0, hs_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_cfg(input logic [3:0] css, wrs, act, hld,
                                         input logic en);
    return {css, wrs, act, hld, 3'b000, en};
  endfunction

  // bus monitor, then pixel driver
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done) done_cnt++;
      if (!cs_n) begin
        cs_len++;
        if (!wr_n) begin wr_len++; db_seen = db; end
        else if (wr_len == 0) pre++;
        else post++;
      end else if (cs_len > 0) begin
        chk(pre == exp_css + exp_wrs, "R2 setup", pre, exp_css + exp_wrs);
        chk(wr_len == exp_act, "R3 strobe", wr_len, exp_act);
        chk(post == exp_hld, "R2 hold", post, exp_hld);
        chk(db_seen == acc_q[words_seen & 255], "R6 data",
            int'(db_seen), int'(acc_q[words_seen & 255]));
        chk(done == (words_seen + 1 == exp_words), "R7 done timing",
            int'(done), int'(words_seen + 1 == exp_words));
        words_seen++;
        cs_len = 0; wr_len = 0; pre = 0; post = 0;
      end
      if (hs_prev || !pix_valid) begin
        pix_valid = drv_on && ($urandom % 10 < 7);
        pix_data  = 16'($urandom);
      end
      hs_prev = pix_valid && pix_ready;
      if (hs_prev) begin
        acc_q[acc_cnt & 255] = pix_data;
        acc_cnt++;
      end
    end
  end

  task automatic trig(input logic [1:0] c);
    @(negedge clk); trig_ctrl = c; trig_we = 1'b1;
    @(negedge clk); trig_we = 1'b0; trig_ctrl = 2'b00;
  endtask

  task automatic setup(input logic [3:0] css, wrs, act, hld, input int w, h,
                       input logic ie);
    @(negedge clk);
    cfg = mk_cfg(css, wrs, act, hld, 1'b1);
    fw = 8'(w); fh = 8'(h); irq_en = ie;
    exp_css = int'(css); exp_wrs = int'(wrs); exp_hld = int'(hld);
    exp_act = (act == 4'd0) ? 1 : int'(act);
    exp_words = w * h; words_seen = 0; acc_cnt = 0;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 5000 && done_cnt == d0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [3:0] css, wrs, act, hld, input int w, h,
                           input logic ie);
    int d0;
    setup(css, wrs, act, hld, w, h, ie);
    d0 = done_cnt;
    trig(2'b11);
    wait_done(d0);
    chk(words_seen == exp_words, "R6 word count", words_seen, exp_words);
    chk(done_cnt == d0 + 1, "R7 one done", done_cnt - d0, 1);
    chk(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
    chk(irq == ie, "R8 irq per enable", int'(irq), int'(ie));
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cs_n && wr_n, "R1 bus idle", int'({cs_n, wr_n}), 3);
    chk(!busy && !done && !irq && !pix_ready, "R1 flags low",
        int'({busy, done, irq, pix_ready}), 0);
    drv_on = 1'b1;

    // all-zero phase fields: 1-cycle strobe, no setup/hold
    run_frame(4'd0, 4'd0, 4'd0, 4'd0, 3, 2, 1'b1);
    // irq masked still ends busy
    run_frame(4'd1, 4'd2, 4'd3, 4'd1, 2, 2, 1'b0);

    // R8 irq sticks until cleared
    setup(4'd0, 4'd1, 4'd1, 4'd0, 1, 1, 1'b1);
    d0 = done_cnt; trig(2'b11); wait_done(d0);
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R8 irq sticky", int'(irq), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R8 clear", int'(irq), 0);

    // R5 retrigger dropped, R9 mid-frame changes ignored
    setup(4'd3, 4'd2, 4'd4, 4'd2, 4, 2, 1'b1);
    d0 = done_cnt; trig(2'b11);
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R5 busy in frame", int'(busy), 1);
    cfg = mk_cfg(4'd9, 4'd9, 4'd9, 4'd9, 1'b1); fw = 8'd7; fh = 8'd7;
    trig(2'b11);
    wait_done(d0);
    chk(words_seen == 8, "R9 size kept", words_seen, 8);
    repeat (60) @(negedge clk);
    chk(done_cnt == d0 + 1, "R5 retrigger dropped", done_cnt - d0, 1);
    chk(busy == 1'b0 && cs_n, "R5 no new frame", int'(busy), 0);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

    // R4 triggers without full conditions
    setup(4'd1, 4'd1, 4'd1, 4'd1, 2, 2, 1'b1);
    cfg[0] = 1'b0;
    d0 = done_cnt;
    trig(2'b11); repeat (30) @(negedge clk);
    chk(!busy && done_cnt == d0 && words_seen == 0, "R4 enable clear",
        int'(busy), 0);
    cfg[0] = 1'b1;
    trig(2'b10); repeat (30) @(negedge clk);
    chk(!busy && done_cnt == d0, "R4 mode bit clear", int'(busy), 0);
    trig(2'b01); repeat (30) @(negedge clk);
    chk(!busy && done_cnt == d0 && cs_n, "R4 cmd bit clear", int'(busy), 0);

    // R10 zero-size frame
    setup(4'd2, 4'd2, 4'd2, 4'd2, 0, 5, 1'b1);
    d0 = done_cnt;
    @(negedge clk); trig_ctrl = 2'b11; trig_we = 1'b1;
    @(negedge clk); trig_we = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R10 immediate done",
        int'({done, busy}), 2);
    repeat (20) @(negedge clk);
    chk(words_seen == 0 && done_cnt == d0 + 1, "R10 no bus cycle", words_seen, 0);
    chk(irq == 1'b1, "R10 irq", int'(irq), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

    // R2 R3 R6 R11 randomized phase counts and sizes
    for (int k = 0; k < 10; k++)
      run_frame(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                1 + int'($urandom % 4), 1 + int'($urandom % 3),
                1'($urandom));

    drv_on = 1'b0;
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule